// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Logic

This block decides which interrupt a 16550-style serial port reports and whether its single interrupt request line is raised. It receives the pending sources from the rest of the port: line error bits, data-ready, the receive FIFO fill count and its programmed trigger level, a character-timeout flag, and the modem-line change bits. It qualifies each source with its enable bit and picks the most urgent one through a fixed five-level ranking. The result is a byte that software reads to identify the cause. Its upper two bits show whether the FIFOs are switched on.

The block owns two pieces of state. The first is the four-bit enable register. The second is the pending flag for "transmit holder empty", which cannot be derived from the holder's level alone. It is raised when the holder drains, or when the enable register is written while the holder is already empty. It drops when the identification register is read, or when software loads the holder. Both the request and the identification byte follow the inputs and the registered state within the same cycle.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the enable register reads 0, the transmit-empty pending flag is clear, `irq_o` is 0 and the low nibble of `iir_o` is 0x1.
- R2: A write to the enable register stores only bits 3:0 of `ier_wdata_i`; the stored value appears on `ier_o` from the next cycle. Enable bits: 0 received data, 1 transmit empty, 2 line status, 3 modem status.
- R3: The sources are ranked as follows, highest first, each with its low-nibble code: line status 0x6, character timeout 0xC, received data 0x4, transmit empty 0x2, modem status 0x0. A lower-ranked pending source is reported when every higher-ranked one is idle.
- R4: Line status is pending only when enable bit 2 is set and at least one bit of `lsr_err_i` is set. These bits are overrun, parity, framing and break.
- R5: Received data is pending only when enable bit 0 and `data_ready_i` are set. With `fifo_en_i`=1 it additionally needs `rx_count_i` >= `rx_trig_i`.
- R6: Character timeout is pending whenever `timeout_pend_i` is 1. It has no enable bit of its own.
- R7: While the whole enable register is 0, `irq_o` is 0 and the low nibble of `iir_o` is 0x1, whatever sources are pending.
- R8: `iir_o[7:6]` are both 1 when `fifo_en_i`=1 and both 0 otherwise. `iir_o[5:4]` are always 0.
- R9: A cycle with `iir_rd_i`=1 clears the transmit-empty pending flag, and the new priority shows in the next cycle.
- R10: The pending flag is set by a `thr_set_i` pulse, or by an enable write while `thr_empty_i`=1. It is cleared by `thr_clr_i`. An enable write with `thr_empty_i`=0 leaves it unchanged.
- R11: When events coincide in one cycle, `thr_clr_i` wins over any set, and a set wins over the clear from `iir_rd_i`.
- R12: Modem status is pending only when enable bit 3 is set and at least one bit of `msr_delta_i` is set.
- R13: `irq_o` and `iir_o` respond to input changes in the same cycle, with no register stage. `irq_o` is 1 exactly when the low nibble differs from 0x1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Write strobe for the enable register |
| ier_wdata_i | input | 8 | Write data for the enable register |
| iir_rd_i | input | 1 | Read strobe for the identification register |
| thr_empty_i | input | 1 | Transmit holder currently empty (level) |
| thr_set_i | input | 1 | Transmit holder just became empty (pulse) |
| thr_clr_i | input | 1 | Transmit holder was loaded (pulse) |
| fifo_en_i | input | 1 | FIFO mode active |
| lsr_err_i | input | 4 | Overrun, parity, framing, break |
| data_ready_i | input | 1 | Receive data ready |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| timeout_pend_i | input | 1 | Character timeout pending |
| msr_delta_i | input | 4 | Modem line change bits |
| ier_o | output | 4 | Stored enable register |
| iir_o | output | 8 | Interrupt identification value |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The transmit-empty pending flag can be hit by a set and a clear in the same cycle. A drain pulse or an enable write with the holder empty can land together with an identification read. A holder load can also land together with a drain pulse. The bench provokes both pairings, then reads the identification code of the following cycle. In the first case the code must still show 0x2; in the second, the flag must be gone. The priority ranking is judged by stacking sources one at a time and checking that the reported code always belongs to the highest one present.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MDM  = 4'h0,
    ID_NONE = 4'h1,
    ID_THR  = 4'h2,
    ID_RXD  = 4'h4,
    ID_LINE = 4'h6,
    ID_TMO  = 4'hC
  } irq_id_e;

  localparam int unsigned NUM_SRC = 5;

  // source slot index, 0 = highest rank
  localparam int unsigned SRC_LINE = 0;
  localparam int unsigned SRC_TMO  = 1;
  localparam int unsigned SRC_RXD  = 2;
  localparam int unsigned SRC_THR  = 3;
  localparam int unsigned SRC_MDM  = 4;

  // enable register bit positions
  localparam int unsigned EN_RXD  = 0;
  localparam int unsigned EN_THR  = 1;
  localparam int unsigned EN_LINE = 2;
  localparam int unsigned EN_MDM  = 3;
  localparam int unsigned EN_W    = 4;

  function automatic irq_id_e src_code(input int unsigned idx);
    case (idx)
      SRC_LINE: return ID_LINE;
      SRC_TMO:  return ID_TMO;
      SRC_RXD:  return ID_RXD;
      SRC_THR:  return ID_THR;
      SRC_MDM:  return ID_MDM;
      default:  return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W    = 5,
  parameter bit          HAS_FIFO = 1'b1
) (
  input  logic [EN_W-1:0]    en_i,
  input  logic               fifo_en_i,
  input  logic [3:0]         lsr_err_i,
  input  logic               data_ready_i,
  input  logic [CNT_W-1:0]   rx_count_i,
  input  logic [CNT_W-1:0]   rx_trig_i,
  input  logic               timeout_pend_i,
  input  logic               thr_pend_i,
  input  logic [3:0]         msr_delta_i,
  output logic [NUM_SRC-1:0] req_o
);

  logic rx_level_ok;

  generate
    if (HAS_FIFO) begin : g_fifo
      assign rx_level_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);
    end else begin : g_nofifo
      assign rx_level_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    req_o           = '0;
    req_o[SRC_LINE] = en_i[EN_LINE] && (|lsr_err_i);
    req_o[SRC_TMO]  = timeout_pend_i;
    req_o[SRC_RXD]  = en_i[EN_RXD] && data_ready_i && rx_level_ok;
    req_o[SRC_THR]  = en_i[EN_THR] && thr_pend_i;
    req_o[SRC_MDM]  = en_i[EN_MDM] && (|msr_delta_i);
  end

  // R4: line errors without enable never request
  always_comb begin
    if (!en_i[EN_LINE]) a_r4_line_needs_en: assert (!req_o[SRC_LINE]);
  end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0] req_i,
  output irq_id_e      id_o,
  output logic         valid_o
);

  always_comb begin
    id_o = ID_NONE;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = src_code(i);
    end
    valid_o = |req_i;
  end

  // R3: top-ranked request always wins
  always_comb begin
    if (req_i[0]) a_r3_top_wins: assert (id_o == src_code(0));
  end

endmodule

// File: rtl/uart_irq_state.sv
module uart_irq_state
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ier_wr_i,
  input  logic [7:0]      ier_wdata_i,
  input  logic            iir_rd_i,
  input  logic            thr_empty_i,
  input  logic            thr_set_i,
  input  logic            thr_clr_i,
  output logic [EN_W-1:0] en_o,
  output logic            thr_pend_o
);

  logic en_set;

  assign en_set = thr_set_i || (ier_wr_i && thr_empty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       en_o <= '0;
    else if (ier_wr_i) en_o <= ier_wdata_i[EN_W-1:0];
  end

  // holder load > set > identification read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        thr_pend_o <= 1'b0;
    else if (thr_clr_i) thr_pend_o <= 1'b0;
    else if (en_set)    thr_pend_o <= 1'b1;
    else if (iir_rd_i)  thr_pend_o <= 1'b0;
  end

  a_r2_low_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_wr_i |=> en_o == $past(ier_wdata_i[EN_W-1:0]));

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && !thr_set_i && !ier_wr_i) |=> !thr_pend_o);

  a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_clr_i |=> !thr_pend_o);

  a_r11_set_beats_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_set_i && !thr_clr_i) |=> thr_pend_o);

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_irq_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter bit          HAS_FIFO   = 1'b1,
  localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [7:0]       ier_wdata_i,
  input  logic             iir_rd_i,
  input  logic             thr_empty_i,
  input  logic             thr_set_i,
  input  logic             thr_clr_i,
  input  logic             fifo_en_i,
  input  logic [3:0]       lsr_err_i,
  input  logic             data_ready_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             timeout_pend_i,
  input  logic [3:0]       msr_delta_i,
  output logic [3:0]       ier_o,
  output logic [7:0]       iir_o,
  output logic             irq_o
);

  logic [EN_W-1:0]    en_q;
  logic               thr_pend_q;
  logic [NUM_SRC-1:0] req;
  irq_id_e            win_id;
  logic               win_valid;
  logic               any_en;
  irq_id_e            id_out;

  uart_irq_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ier_wr_i   (ier_wr_i),
    .ier_wdata_i(ier_wdata_i),
    .iir_rd_i   (iir_rd_i),
    .thr_empty_i(thr_empty_i),
    .thr_set_i  (thr_set_i),
    .thr_clr_i  (thr_clr_i),
    .en_o       (en_q),
    .thr_pend_o (thr_pend_q)
  );

  uart_irq_src #(.CNT_W(CNT_W), .HAS_FIFO(HAS_FIFO)) u_src (
    .en_i          (en_q),
    .fifo_en_i     (fifo_en_i),
    .lsr_err_i     (lsr_err_i),
    .data_ready_i  (data_ready_i),
    .rx_count_i    (rx_count_i),
    .rx_trig_i     (rx_trig_i),
    .timeout_pend_i(timeout_pend_i),
    .thr_pend_i    (thr_pend_q),
    .msr_delta_i   (msr_delta_i),
    .req_o         (req)
  );

  uart_irq_prio #(.N(NUM_SRC)) u_prio (
    .req_i  (req),
    .id_o   (win_id),
    .valid_o(win_valid)
  );

  // a fully cleared enable register silences every source
  assign any_en = |en_q;
  assign id_out = any_en ? win_id : ID_NONE;
  assign irq_o  = any_en && win_valid;
  assign ier_o  = en_q;
  assign iir_o  = {{2{fifo_en_i}}, 2'b00, id_out};

  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o == 4'h0) |-> (!irq_o && iir_o[3:0] == 4'h1));

  a_r13_irq_matches_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (iir_o[3:0] != 4'h1));

  a_r4_line_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_o[EN_LINE] && |lsr_err_i) |-> iir_o[3:0] == 4'h6);

  a_r8_fifo_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[7:4] == {fifo_en_i, fifo_en_i, 2'b00});

endmodule

// File: tb/tb_uart_irq_id.sv
`timescale 1ns/1ps
module tb_uart_irq_id;

  localparam int unsigned CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 0, iir_rd = 0, thr_empty = 0, thr_set = 0, thr_clr = 0;
  logic [7:0]    ier_wdata = 0;
  logic          fifo_en = 0, data_ready = 0, tmo = 0;
  logic [3:0]    lsr_err = 0, msr_delta = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 0;
  logic [3:0]    ier_o;
  logic [7:0]    iir_o;
  logic          irq_o;

  always #5 clk = ~clk;

  uart_irq_id dut (
    .clk_i(clk), .rst_ni(rst_n), .ier_wr_i(ier_wr), .ier_wdata_i(ier_wdata),
    .iir_rd_i(iir_rd), .thr_empty_i(thr_empty), .thr_set_i(thr_set),
    .thr_clr_i(thr_clr), .fifo_en_i(fifo_en), .lsr_err_i(lsr_err),
    .data_ready_i(data_ready), .rx_count_i(rx_count), .rx_trig_i(rx_trig),
    .timeout_pend_i(tmo), .msr_delta_i(msr_delta),
    .ier_o(ier_o), .iir_o(iir_o), .irq_o(irq_o)
  );

  typedef struct {
    logic       irq;
    logic [7:0] iir;
    logic [3:0] ier;
    string      tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  logic [3:0] m_ier = 0;
  logic       m_pend = 0;

  function automatic exp_t predict(string tag);
    exp_t e;
    logic [3:0] c;
    if (m_ier == 0)                                   c = 4'h1;
    else if (m_ier[2] && |lsr_err)                    c = 4'h6;
    else if (tmo)                                     c = 4'hC;
    else if (m_ier[0] && data_ready && (!fifo_en || rx_count >= rx_trig)) c = 4'h4;
    else if (m_ier[1] && m_pend)                      c = 4'h2;
    else if (m_ier[3] && |msr_delta)                  c = 4'h0;
    else                                              c = 4'h1;
    e.irq = (c != 4'h1);
    e.iir = {fifo_en, fifo_en, 2'b00, c};
    e.ier = m_ier;
    e.tag = tag;
    return e;
  endfunction

  // monitor: compare after combinational settle, before the next edge
  initial begin
    forever begin
      @(chk_ev);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (irq_o !== e.irq || iir_o !== e.iir || ier_o !== e.ier) begin
          n_fail++;
          $display("FAIL %s: irq=%b iir=%h ier=%h expected irq=%b iir=%h ier=%h",
                   e.tag, irq_o, iir_o, ier_o, e.irq, e.iir, e.ier);
        end
      end
    end
  end

  // driver: inputs are set at the falling edge by the caller
  task automatic go(string tag);
    q.push_back(predict(tag));
    ->chk_ev;
    @(posedge clk);
    if (ier_wr) m_ier = ier_wdata[3:0];
    if (thr_clr)                          m_pend = 0;
    else if (thr_set || (ier_wr && thr_empty)) m_pend = 1;
    else if (iir_rd)                      m_pend = 0;
    @(negedge clk);
    ier_wr = 0; iir_rd = 0; thr_set = 0; thr_clr = 0;
  endtask

  task automatic quiet();
    fifo_en = 0; data_ready = 0; tmo = 0; lsr_err = 0; msr_delta = 0;
    rx_count = 0; rx_trig = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    go("R1 reset state");

    // enable write with holder empty: pending appears next cycle
    ier_wr = 1; ier_wdata = 8'hFF; thr_empty = 1;
    go("R2 write cycle still old value");
    thr_empty = 0;
    go("R10 enable write sets pending");

    iir_rd = 1;
    go("R9 read cycle");
    go("R9 after read");

    ier_wr = 1; ier_wdata = 8'h0F; thr_empty = 0;
    go("R10 write without empty");
    go("R10 no pending");

    msr_delta = 4'b0010;
    go("R12 modem change");
    msr_delta = 0;

    fifo_en = 1; data_ready = 1; rx_count = 3; rx_trig = 4;
    go("R5 below trigger R8");
    rx_count = 4;
    go("R5 at trigger");
    rx_count = 5;
    go("R5 above trigger");
    tmo = 1;
    go("R6 timeout over data");
    lsr_err = 4'b1000;
    go("R4 break over timeout R13");
    lsr_err = 4'b0001;
    go("R4 overrun");
    quiet();
    data_ready = 1; rx_count = 0; rx_trig = 8;
    go("R5 non-fifo data ready");
    quiet();

    msr_delta = 4'b0001; thr_set = 1;
    go("R3 modem only");
    go("R3 thr over modem");

    thr_set = 1; iir_rd = 1;
    go("R11 set with read");
    go("R11 set survived read");
    thr_set = 1; thr_clr = 1;
    go("R11 load with set");
    go("R11 load won");
    msr_delta = 0;

    ier_wr = 1; ier_wdata = 8'h00;
    go("R7 write zero");
    lsr_err = 4'b0100; tmo = 1;
    go("R7 quiet with sources");
    quiet();

    ier_wr = 1; ier_wdata = 8'hA5;
    go("R2 upper bits dropped");
    go("R2 stored low nibble");
    lsr_err = 4'b0010;
    go("R4 line enabled");
    lsr_err = 0; fifo_en = 1;
    go("R8 fifo bits no source");

    @(negedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule